// File: doc/BRIEF.md
# Multi-Channel DMA Register Front End

This block is the memory-mapped control and status front end for a bank of DMA channels. Bus reads and writes arrive as 32-bit word accesses. The block decodes each access to a channel register or to one of two global registers. It keeps the per-channel control/status word, the descriptor pointer and a debug scratch word. It turns bus writes into single-cycle start, soft-reset and interrupt-clear pulses for the transfer engines, which sit outside this block.

Every channel except the last shares the main 4 KB window, with bits 11:8 of the offset choosing the channel. The last channel uses a separate 256-byte window, chosen by a window-select input. The engines report completion through set and clear strobes. They also drive the contents of their current descriptor, which software reads back through read-only mirror registers. Read data is registered and appears one cycle after the read strobe.

Top module: `dma_reg_front`

## Requirements
- R1: With the window select at 0, offsets below 0xF00 select channel offset[11:8] for channels 0 to 14, and offset[7:0] selects the register. With the window select at 1, channel 15 is selected and only offset[7:0] is used.
- R2: In a channel, offset 0x00 is control/status and 0x04 is the read/write descriptor pointer, driven on ch_cbaddr_o. Offset 0x20 is a read/write debug word. Offsets 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C read engine descriptor words 0 to 5 of ch_desc_i (word k of channel c at bits [(c*6+k)*32 +: 32]), and writes to them are ignored.
- R3: On a control/status write, bits 0, 23:16 and 29:28 (mask 0x30FF0001) take the written value. Bit 1 (END) and bit 2 (INT) keep their state unless cleared, and every other bit reads 0.
- R4: Writing 1 to bit 1 clears END. Writing 1 to bit 2 clears INT and the channel's global interrupt-status bit, deasserts its ch_irq_o, and pulses ch_iclr_o for one cycle. A clear written in the same cycle as an engine set wins.
- R5: Writing 1 to bit 31 pulses ch_rst_o and clears END, INT and the descriptor pointer. The masked bits still take the written value. Bit 31 never reads back as 1. The debug word and the global interrupt-status bit are left unchanged.
- R6: ch_start_o pulses for one cycle, starting the cycle after the write, only when a control/status write changes ACTIVE (bit 0) from 0 to 1.
- R7: An engine strobe ch_end_set_i sets END. ch_int_set_i sets INT, the global interrupt-status bit and ch_irq_o. ch_done_i clears ACTIVE, and it overrides a write of ACTIVE in the same cycle.
- R8: Main-window offset 0xFE0 reads the global interrupt status, one bit per channel, and writes to it are ignored.
- R9: Main-window offset 0xFF0 is the global enable. It holds 16 bits, is driven on ch_en_o, resets to 0xFFFF and reads back zero-extended.
- R10: Writing bit 30 (abort) has no effect: it reads 0 and causes no pulse.
- R11: An access with bus_be other than 4'hF, or with offset bits 1:0 not zero, is ignored and reads 0. Undefined offsets read 0 and ignore writes.
- R12: bus_rdata is updated on the clock edge where bus_rd is high and holds its value otherwise.
- R13: After reset, every control/status word, descriptor pointer, interrupt line, pulse output and bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_hi_win | input | 1 | 1 selects the last channel's separate window |
| bus_addr | input | 12 | Byte offset within the selected window |
| bus_be | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| ch_end_set_i | input | NCH | Engine: set END |
| ch_int_set_i | input | NCH | Engine: raise interrupt |
| ch_done_i | input | NCH | Engine: clear ACTIVE |
| ch_desc_i | input | NCH*192 | Engine current descriptor, six words per channel |
| ch_start_o | output | NCH | Start pulse |
| ch_rst_o | output | NCH | Soft-reset pulse |
| ch_iclr_o | output | NCH | Interrupt-clear pulse |
| ch_irq_o | output | NCH | Interrupt line per channel |
| ch_cbaddr_o | output | NCH*32 | Descriptor pointer per channel |
| ch_en_o | output | NCH | Global enable per channel |

## Verification
The bench builds the block with its default of sixteen channels. This puts both the shared window and the separate window of the last channel within reach, together with the unmapped slot at main-window offsets 0xF00 and above. Channel indices 0 through 14 in offset bits 11:8 are all decodable, so both the edge case of channel 14 and the diverted channel 15 get exercised. Same-cycle collisions between engine strobes and bus clears are driven on purpose to confirm which side wins.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;
  localparam int DW         = 32;
  localparam int DESC_WORDS = 6;

  localparam logic [7:0] OFF_CS   = 8'h00;
  localparam logic [7:0] OFF_CB   = 8'h04;
  localparam logic [7:0] OFF_MLO  = 8'h08;
  localparam logic [7:0] OFF_MHI  = 8'h1C;
  localparam logic [7:0] OFF_DBG  = 8'h20;

  localparam logic [11:0] OFF_GINT = 12'hFE0;
  localparam logic [11:0] OFF_GEN  = 12'hFF0;
  localparam logic [11:0] OFF_GLOB = 12'hF00;

  localparam int B_ACT  = 0;
  localparam int B_END  = 1;
  localparam int B_INT  = 2;
  localparam int B_SRST = 31;

  localparam logic [DW-1:0] CS_WMASK = 32'h30FF_0001;
endpackage

// File: rtl/dmarf_decode.sv
module dmarf_decode
  import dmarf_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic           hi_win,
  input  logic [11:0]    addr,
  input  logic [3:0]     be,
  output logic           acc_ok,
  output logic [NCH-1:0] ch_hit,
  output logic [7:0]     reg_off,
  output logic           hit_gint,
  output logic           hit_gen
);
  always_comb begin
    acc_ok   = (be == 4'hF) && (addr[1:0] == 2'b00);
    reg_off  = addr[7:0];
    ch_hit   = '0;
    hit_gint = 1'b0;
    hit_gen  = 1'b0;
    if (acc_ok) begin
      if (hi_win) begin
        ch_hit[NCH-1] = 1'b1;
      end else if (addr < OFF_GLOB) begin
        for (int c = 0; c < NCH-1; c++) begin
          if (addr[11:8] == 4'(c)) ch_hit[c] = 1'b1;
        end
      end else begin
        hit_gint = (addr == OFF_GINT);
        hit_gen  = (addr == OFF_GEN);
      end
    end
  end
endmodule

// File: rtl/dmarf_chan.sv
module dmarf_chan
  import dmarf_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel,
  input  logic                     wr,
  input  logic [7:0]               reg_off,
  input  logic [DW-1:0]            wdata,
  input  logic                     end_set,
  input  logic                     int_set,
  input  logic                     done,
  input  logic [DESC_WORDS*DW-1:0] desc,
  output logic [DW-1:0]            cbaddr,
  output logic                     start_p,
  output logic                     srst_p,
  output logic                     iclr_p,
  output logic                     iclr_now,
  output logic [DW-1:0]            rd_val
);
  logic [DW-1:0] cs_q, cs_d, cb_q, cb_d, dbg_q, dbg_d;
  logic          start_d, srst_d, iclr_d;
  logic          cs_wr, cb_wr, dbg_wr, clr_end, clr_int, cs_en;
  logic [2:0]    mir_idx;

  always_comb begin
    cs_wr   = sel & wr & (reg_off == OFF_CS);
    cb_wr   = sel & wr & (reg_off == OFF_CB);
    dbg_wr  = sel & wr & (reg_off == OFF_DBG);
    clr_end = cs_wr & (wdata[B_END] | wdata[B_SRST]);
    clr_int = cs_wr & (wdata[B_INT] | wdata[B_SRST]);
    cs_en   = cs_wr | end_set | int_set | done;

    cs_d = cs_wr ? (wdata & CS_WMASK) : (cs_q & CS_WMASK);
    if (done) cs_d[B_ACT] = 1'b0;
    cs_d[B_END] = (cs_q[B_END] | end_set) & ~clr_end;
    cs_d[B_INT] = (cs_q[B_INT] | int_set) & ~clr_int;

    if (cs_wr && wdata[B_SRST]) cb_d = '0;
    else if (cb_wr)             cb_d = wdata;
    else                        cb_d = cb_q;
    dbg_d = dbg_wr ? wdata : dbg_q;

    start_d  = cs_wr & wdata[B_ACT] & ~cs_q[B_ACT];
    srst_d   = cs_wr & wdata[B_SRST];
    iclr_d   = cs_wr & wdata[B_INT];
    iclr_now = iclr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= '0;
      cb_q <= '0;
      dbg_q <= '0;
      start_p <= 1'b0;
      srst_p <= 1'b0;
      iclr_p <= 1'b0;
    end else begin
      if (cs_en) cs_q <= cs_d;
      if (cb_wr || cs_wr) cb_q <= cb_d;
      if (dbg_wr) dbg_q <= dbg_d;
      start_p <= start_d;
      srst_p <= srst_d;
      iclr_p <= iclr_d;
    end
  end

  always_comb begin
    mir_idx = reg_off[4:2] - 3'd2;
    rd_val  = '0;
    if (reg_off == OFF_CS)       rd_val = cs_q;
    else if (reg_off == OFF_CB)  rd_val = cb_q;
    else if (reg_off == OFF_DBG) rd_val = dbg_q;
    else if (reg_off >= OFF_MLO && reg_off <= OFF_MHI && reg_off[1:0] == 2'b00)
      rd_val = desc[32'(mir_idx)*DW +: DW];
  end

  assign cbaddr = cb_q;
endmodule

// File: rtl/dmarf_glob.sv
module dmarf_glob
  import dmarf_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_wr,
  input  logic [NCH-1:0] en_wdata,
  input  logic [NCH-1:0] int_set,
  input  logic [NCH-1:0] int_clr,
  output logic [NCH-1:0] en_q,
  output logic [NCH-1:0] ist_q
);
  logic [NCH-1:0] en_d, ist_d;
  logic           ist_en;

  always_comb begin
    en_d   = en_wr ? en_wdata : en_q;
    ist_d  = (ist_q | int_set) & ~int_clr;
    ist_en = |(int_set | int_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '1;
      ist_q <= '0;
    end else begin
      if (en_wr)  en_q  <= en_d;
      if (ist_en) ist_q <= ist_d;
    end
  end
endmodule

// File: rtl/dma_reg_front.sv
module dma_reg_front
  import dmarf_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_hi_win,
  input  logic [11:0]                  bus_addr,
  input  logic [3:0]                   bus_be,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  input  logic [NCH-1:0]               ch_end_set_i,
  input  logic [NCH-1:0]               ch_int_set_i,
  input  logic [NCH-1:0]               ch_done_i,
  input  logic [NCH*DESC_WORDS*32-1:0] ch_desc_i,
  output logic [NCH-1:0]               ch_start_o,
  output logic [NCH-1:0]               ch_rst_o,
  output logic [NCH-1:0]               ch_iclr_o,
  output logic [NCH-1:0]               ch_irq_o,
  output logic [NCH*32-1:0]            ch_cbaddr_o,
  output logic [NCH-1:0]               ch_en_o
);
  localparam int DESC_BITS = DESC_WORDS * DW;

  logic           acc_ok, hit_gint, hit_gen;
  logic [NCH-1:0] ch_hit, iclr_now;
  logic [7:0]     reg_off;
  logic [DW-1:0]  ch_rd [NCH];
  logic [NCH-1:0] en_q, ist_q;
  logic [DW-1:0]  rdata_d, rdata_q;

  dmarf_decode #(.NCH(NCH)) u_dec (
    .hi_win(bus_hi_win), .addr(bus_addr), .be(bus_be),
    .acc_ok(acc_ok), .ch_hit(ch_hit), .reg_off(reg_off),
    .hit_gint(hit_gint), .hit_gen(hit_gen)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dmarf_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .sel(ch_hit[c]), .wr(bus_wr), .reg_off(reg_off), .wdata(bus_wdata),
      .end_set(ch_end_set_i[c]), .int_set(ch_int_set_i[c]), .done(ch_done_i[c]),
      .desc(ch_desc_i[c*DESC_BITS +: DESC_BITS]),
      .cbaddr(ch_cbaddr_o[c*DW +: DW]),
      .start_p(ch_start_o[c]), .srst_p(ch_rst_o[c]), .iclr_p(ch_iclr_o[c]),
      .iclr_now(iclr_now[c]), .rd_val(ch_rd[c])
    );
  end

  dmarf_glob #(.NCH(NCH)) u_glob (
    .clk(clk), .rst_n(rst_n),
    .en_wr(bus_wr & hit_gen), .en_wdata(bus_wdata[NCH-1:0]),
    .int_set(ch_int_set_i), .int_clr(iclr_now),
    .en_q(en_q), .ist_q(ist_q)
  );

  always_comb begin
    rdata_d = '0;
    for (int c = 0; c < NCH; c++) begin
      if (ch_hit[c]) rdata_d = rdata_d | ch_rd[c];
    end
    if (hit_gint) rdata_d = DW'(ist_q);
    if (hit_gen)  rdata_d = DW'(en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign ch_irq_o  = ist_q;
  assign ch_en_o   = en_q;
endmodule

// File: rtl/dma_reg_front_chk.sv
module dma_reg_front_chk #(
  parameter int NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic           bus_rd,
  input logic [31:0]    bus_rdata,
  input logic [NCH-1:0] ch_int_set_i,
  input logic [NCH-1:0] ch_start_o,
  input logic [NCH-1:0] ch_rst_o,
  input logic [NCH-1:0] ch_irq_o,
  input logic [NCH-1:0] ch_en_o
);
  assert_start_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_start_o) |-> $past(bus_wr));
  assert_one_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_start_o));
  assert_srst_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_rst_o) |-> $past(bus_wr));
  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ch_irq_o & ~$past(ch_irq_o))) |-> (|$past(ch_int_set_i)));
  assert_irq_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~ch_irq_o & $past(ch_irq_o))) |-> $past(bus_wr));
  assert_enable_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch_en_o) |-> $past(bus_wr));
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

bind dma_reg_front dma_reg_front_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .ch_int_set_i(ch_int_set_i),
  .ch_start_o(ch_start_o), .ch_rst_o(ch_rst_o),
  .ch_irq_o(ch_irq_o), .ch_en_o(ch_en_o)
);

// File: tb/dma_reg_front_bench.sv
module dma_reg_front_bench;
  localparam int NCH = 16;

  logic                 clk, rst_n, bus_hi_win, bus_wr, bus_rd;
  logic [11:0]          bus_addr;
  logic [3:0]           bus_be;
  logic [31:0]          bus_wdata, bus_rdata;
  logic [NCH-1:0]       ch_end_set_i, ch_int_set_i, ch_done_i;
  logic [NCH*192-1:0]   ch_desc_i;
  logic [NCH-1:0]       ch_start_o, ch_rst_o, ch_iclr_o, ch_irq_o, ch_en_o;
  logic [NCH*32-1:0]    ch_cbaddr_o;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  dma_reg_front #(.NCH(NCH)) u_dma_reg_front (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always_comb
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 6; k++)
        ch_desc_i[(c*6+k)*32 +: 32] = {16'hA5C0, 8'(c), 8'(k)};

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data after each read edge
  always @(posedge clk) begin
    if (bus_rd) begin
      #2;
      if (exp_q.size() > 0) chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic win, input logic [11:0] a, input logic [31:0] d,
                    input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_hi_win = win; bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'hF;
  endtask

  task automatic rd(input logic win, input logic [11:0] a, input logic [31:0] exp,
                    input string tag, input logic [3:0] be = 4'hF);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_hi_win = win; bus_addr = a; bus_be = be; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_be = 4'hF;
  endtask

  task automatic eng(input logic [NCH-1:0] e, input logic [NCH-1:0] i, input logic [NCH-1:0] d);
    @(negedge clk);
    ch_end_set_i = e; ch_int_set_i = i; ch_done_i = d;
    @(negedge clk);
    ch_end_set_i = '0; ch_int_set_i = '0; ch_done_i = '0;
  endtask

  initial begin
    #1000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_hi_win = 0; bus_addr = '0; bus_be = 4'hF; bus_wr = 0; bus_rd = 0;
    bus_wdata = '0; ch_end_set_i = '0; ch_int_set_i = '0; ch_done_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(bus_rdata, 32'h0, "R13 rdata");
    chk(32'(ch_irq_o), 32'h0, "R13 irq");
    chk(ch_cbaddr_o[3*32 +: 32], 32'h0, "R13 cbaddr");
    rd(0, 12'h300, 32'h0, "R13 cs ch3");
    rd(0, 12'hFF0, 32'h0000FFFF, "R9 enable reset");
    rd(0, 12'hFE0, 32'h0, "R8 int status reset");
    // R3 mask
    wr(0, 12'h200, 32'h0FFF_FFF8);
    rd(0, 12'h200, 32'h00FF_0000, "R3 masked write");
    wr(0, 12'h200, 32'h3000_0000);
    rd(0, 12'h200, 32'h3000_0000, "R3 rewrite");
    // R6 start
    wr(0, 12'h500, 32'h1);
    chk(32'(ch_start_o), 32'h0020, "R6 start pulse");
    @(negedge clk);
    chk(32'(ch_start_o), 32'h0, "R6 pulse width");
    wr(0, 12'h500, 32'h1);
    chk(32'(ch_start_o), 32'h0, "R6 no restart while active");
    rd(0, 12'h500, 32'h1, "R6 active readback");
    // R7 engine
    eng('0, '0, 16'h0020);
    rd(0, 12'h500, 32'h0, "R7 done clears active");
    eng(16'h0020, 16'h0020, '0);
    rd(0, 12'h500, 32'h6, "R7 end int set");
    chk(32'(ch_irq_o), 32'h0020, "R7 irq");
    rd(0, 12'hFE0, 32'h0020, "R7 global status");
    // R8 ignore writes
    wr(0, 12'hFE0, 32'h0);
    rd(0, 12'hFE0, 32'h0020, "R8 write ignored");
    // R4 clears
    wr(0, 12'h500, 32'h2);
    rd(0, 12'h500, 32'h4, "R4 end cleared");
    chk(32'(ch_irq_o), 32'h0020, "R4 irq kept");
    wr(0, 12'h500, 32'h4);
    chk(32'(ch_iclr_o), 32'h0020, "R4 iclr pulse");
    chk(32'(ch_irq_o), 32'h0, "R4 irq cleared");
    rd(0, 12'h500, 32'h0, "R4 int cleared");
    // R4 priority: clear with same-cycle set
    @(negedge clk);
    bus_hi_win = 0; bus_addr = 12'h600; bus_wdata = 32'h4; bus_wr = 1; ch_int_set_i = 16'h0040;
    @(negedge clk);
    bus_wr = 0; ch_int_set_i = '0;
    chk(32'(ch_irq_o), 32'h0, "R4 clear wins irq");
    rd(0, 12'h600, 32'h0, "R4 clear wins cs");
    // R7 done overrides write of active
    @(negedge clk);
    bus_addr = 12'h100; bus_wdata = 32'h1; bus_wr = 1; ch_done_i = 16'h0002;
    @(negedge clk);
    bus_wr = 0; ch_done_i = '0;
    rd(0, 12'h100, 32'h0, "R7 done overrides");
    // R5 soft reset
    eng(16'h0080, 16'h0080, '0);
    wr(0, 12'h704, 32'h1234_5670);
    wr(0, 12'h720, 32'h0000_DEAD);
    wr(0, 12'h700, 32'h8000_0001);
    chk(32'(ch_rst_o), 32'h0080, "R5 reset pulse");
    chk(32'(ch_start_o), 32'h0080, "R5 start after reset");
    rd(0, 12'h700, 32'h1, "R5 cs after reset");
    rd(0, 12'h704, 32'h0, "R5 cbaddr cleared");
    rd(0, 12'h720, 32'h0000_DEAD, "R5 debug kept");
    chk(32'(ch_irq_o), 32'h0080, "R5 global int kept");
    // R10 abort
    wr(0, 12'h800, 32'h4000_0000);
    chk(32'(ch_start_o | ch_rst_o | ch_iclr_o), 32'h0, "R10 no pulses");
    rd(0, 12'h800, 32'h0, "R10 abort reads 0");
    // R1 windows
    wr(1, 12'h004, 32'hCAFE_0004);
    chk(ch_cbaddr_o[15*32 +: 32], 32'hCAFE_0004, "R1 ch15 window");
    rd(1, 12'h004, 32'hCAFE_0004, "R1 ch15 read");
    wr(0, 12'hE04, 32'hBEEF_0E04);
    chk(ch_cbaddr_o[14*32 +: 32], 32'hBEEF_0E04, "R1 ch14");
    chk(ch_cbaddr_o[15*32 +: 32], 32'hCAFE_0004, "R1 ch15 untouched");
    rd(0, 12'hF04, 32'h0, "R1 main above F00");
    // R2 mirrors
    rd(0, 12'h310, 32'hA5C0_0302, "R2 mirror ch3 w2");
    rd(1, 12'h01C, 32'hA5C0_0F05, "R2 mirror ch15 w5");
    wr(0, 12'h30C, 32'h0);
    rd(0, 12'h30C, 32'hA5C0_0301, "R2 mirror write ignored");
    // R9 enable
    wr(0, 12'hFF0, 32'hFFFF_1234);
    chk(32'(ch_en_o), 32'h1234, "R9 enable out");
    rd(0, 12'hFF0, 32'h1234, "R9 enable read");
    // R11 partial / undefined
    wr(0, 12'h904, 32'h5555_0000, 4'h3);
    rd(0, 12'h904, 32'h0, "R11 partial write ignored");
    rd(0, 12'h720, 32'h0, "R11 partial read", 4'h1);
    wr(0, 12'h924, 32'h1);
    rd(0, 12'h924, 32'h0, "R11 undefined offset");
    // R12 hold
    rd(0, 12'h720, 32'h0000_DEAD, "R12 read");
    repeat (3) @(negedge clk);
    chk(bus_rdata, 32'h0000_DEAD, "R12 hold");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule